// File: doc/BRIEF.md
# Banked Host Register Address Decoder

This block sits between an asynchronous-style host I/O bus and a small register file split into eight banks. Each bank has a 16-byte window made of four doubleword slots. A host cycle counts only when the address-enable input is low and the upper address bits equal a programmable I/O base. The decoder keeps a 3-bit bank pointer. It turns each valid cycle into a one-hot select for one of the internal banks, a read drive enable for the data bus, and an active-low chip select for a peripheral that owns one reserved bank.

The bank pointer lives in the top doubleword slot of every window, so software can always reach it, whatever bank is selected. Its high byte is a fixed signature that drivers use to find the block on the bus. Banks 4 to 6 are empty. Bank 7 sends its lower half to an external device. Address and address enable can be frozen by a rising address strobe, which suits multiplexed buses. On buses that never raise the strobe, the capture path is transparent.

Top module: `hbd_top`

## Requirements
- R1: After reset the bank pointer is 0.
- R2: A cycle is valid only when aen_i is 0 and addr_i[15:4] equals io_base_i. With aen_i high or a base mismatch, no select is asserted, data_oe_o stays low and ext_cs_n_o stays high.
- R3: A write to the bank-select slot (addr_i[3:2] = 3) with be_i[2] set loads wdata_i[18:16] into the bank pointer on the next clock edge. This works in every bank. A write with be_i[2] clear, including a byte write to lane 3 alone, leaves the pointer unchanged.
- R4: A read of the bank-select slot is accepted in any bank and raises data_oe_o. It returns rdata_o[23:16] = {5'b0, bank} and rdata_o[31:24] = 8'h33, with the other lanes at 0. This holds for byte, word and doubleword enables alike.
- R5: For banks 0 to 3, a valid access to slots 0 to 2 asserts exactly reg_sel_o[bank], and a read also raises data_oe_o.
- R6: ext_cs_n_o is low exactly when the cycle is valid, the bank is 7 and addr_i[3] is 0. It follows the same strobe capture as the address.
- R7: In banks 4, 5 and 6, slots 0 to 2 assert no select and never raise data_oe_o, so writes there have no effect and reads leave the bus undriven.
- R8: While the strobe has been high since the previous clock edge, the decoder works on the address and aen_i captured at the clock edge where the strobe was first seen high. When the strobe is low, live inputs pass straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_base_i | input | 12 | Programmed I/O base compared with address bits 15:4 |
| as_i | input | 1 | Address strobe; a rising edge freezes address and aen_i |
| aen_i | input | 1 | Address enable, active low for host I/O cycles |
| addr_i | input | 14 | Doubleword address, bits 15:2 |
| rd_i | input | 1 | Read cycle in progress |
| wr_i | input | 1 | Write cycle in progress |
| be_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Write data |
| reg_sel_o | output | 4 | One-hot select for internal banks 0 to 3 |
| data_oe_o | output | 1 | Data-bus drive enable for reads |
| rdata_o | output | 32 | Read data for the bank-select slot |
| ext_cs_n_o | output | 1 | Active-low chip select for the reserved bank |

## Verification
Selects, chip select, drive enable and read data are combinational from the captured address. They are due in the same cycle as the stimulus, so the bench drives on the falling edge and samples 2 ns later, before the next rising edge. A bank-pointer write takes effect at the next rising edge. The bench updates its model only after that edge and checks the new bank on the following cycle. Strobe capture needs one edge to register the strobe level, so the frozen-address checks begin the cycle after the strobe is first seen high.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
    localparam int ADDR_W    = 16;
    localparam int BASE_W    = ADDR_W - 4;
    localparam int BANK_W    = 3;
    localparam int INT_BANKS = 4;
    localparam int EXT_BANK  = 7;
    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam logic [7:0] SIG_BYTE = 8'h33;
    localparam logic [1:0] BSEL_SLOT = 2'b11;

    typedef struct packed {
        logic              aen;
        logic [ADDR_W-1:2] addr;
    } hbus_addr_t;

    typedef struct packed {
        logic valid;
        logic bsel;
        logic low_half;
    } dec_t;

    function automatic logic [DATA_W-1:0] bsel_word(input logic [BANK_W-1:0] bank);
        return {SIG_BYTE, {(8-BANK_W){1'b0}}, bank, 16'h0000};
    endfunction
endpackage

// File: rtl/hbd_addr_latch.sv
module hbd_addr_latch #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe_i,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] eff_o
);
    logic         strobe_q;
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe_i;
    end

    always_ff @(posedge clk) begin
        if (!strobe_q) held_q <= live_i;
    end

    assign eff_o = strobe_q ? held_q : live_i;

    AST_FROZEN_ADDR: assert property (@(posedge clk) disable iff (rst)
        (strobe_q && $past(strobe_q)) |-> $stable(eff_o)); // R8
endmodule

// File: rtl/hbd_window.sv
module hbd_window
    import hbd_pkg::*;
(
    input  logic [BASE_W-1:0] base_i,
    input  hbus_addr_t        eff_i,
    output dec_t              dec_o
);
    logic hit;

    assign hit            = !eff_i.aen && (eff_i.addr[ADDR_W-1:4] == base_i);
    assign dec_o.valid    = hit;
    assign dec_o.bsel     = hit && (eff_i.addr[3:2] == BSEL_SLOT);
    assign dec_o.low_half = hit && !eff_i.addr[3];
endmodule

// File: rtl/hbd_bank_reg.sv
module hbd_bank_reg
    import hbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] bank_o
);
    always_ff @(posedge clk) begin
        if (rst)          bank_o <= '0;
        else if (wr_en_i) bank_o <= wdata_i;
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(bank_o)); // R3
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (bank_o == $past(wdata_i))); // R3
endmodule

// File: rtl/hbd_top.sv
module hbd_top
    import hbd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BASE_W-1:0]    io_base_i,
    input  logic                 as_i,
    input  logic                 aen_i,
    input  logic [ADDR_W-1:2]    addr_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    input  logic [BE_W-1:0]      be_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [INT_BANKS-1:0] reg_sel_o,
    output logic                 data_oe_o,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 ext_cs_n_o
);
    localparam int LW = $bits(hbus_addr_t);

    hbus_addr_t        live, eff;
    dec_t              dec;
    logic [BANK_W-1:0] bank;
    logic              bank_wr;
    logic              int_bank;
    logic              unused_bits;

    assign live.aen  = aen_i;
    assign live.addr = addr_i;

    hbd_addr_latch #(.W(LW)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (as_i),
        .live_i   (live),
        .eff_o    (eff)
    );

    hbd_window u_win (
        .base_i (io_base_i),
        .eff_i  (eff),
        .dec_o  (dec)
    );

    assign bank_wr = wr_i && dec.bsel && be_i[2];

    hbd_bank_reg u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (bank_wr),
        .wdata_i (wdata_i[16+BANK_W-1:16]),
        .bank_o  (bank)
    );

    assign int_bank = (int'(bank) < INT_BANKS);

    for (genvar g = 0; g < INT_BANKS; g++) begin : g_sel
        assign reg_sel_o[g] = dec.valid && !dec.bsel && (int'(bank) == g);
    end

    assign data_oe_o  = rd_i && (dec.bsel || (dec.valid && int_bank));
    assign rdata_o    = dec.bsel ? bsel_word(bank) : '0;
    assign ext_cs_n_o = !(dec.low_half && (int'(bank) == EXT_BANK));

    assign unused_bits = ^{wdata_i[DATA_W-1:16+BANK_W], wdata_i[15:0], be_i[3], be_i[1:0]};

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_sel_o)); // R5
    AST_EXT_CS_BANK: assert property (@(posedge clk) disable iff (rst)
        !ext_cs_n_o |-> (bank == BANK_W'(EXT_BANK))); // R6
    AST_EMPTY_BANKS: assert property (@(posedge clk) disable iff (rst)
        (int'(bank) >= INT_BANKS) |-> (reg_sel_o == '0)); // R7
    AST_AEN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (eff.aen) |-> (!data_oe_o && ext_cs_n_o && reg_sel_o == '0)); // R2
endmodule

// File: tb/hbd_top_tb_top.sv
module hbd_top_tb_top;
    import hbd_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [BASE_W-1:0]    io_base;
    logic                 as_s, aen, rd, wr;
    logic [ADDR_W-1:2]    addr;
    logic [BE_W-1:0]      be;
    logic [DATA_W-1:0]    wdata;
    logic [INT_BANKS-1:0] reg_sel;
    logic                 data_oe, ext_cs_n;
    logic [DATA_W-1:0]    rdata;

    int checks = 0;
    int fails  = 0;
    logic [2:0] bank_m;

    always #5 clk = ~clk;

    hbd_top dut_i (
        .clk(clk), .rst(rst), .io_base_i(io_base), .as_i(as_s), .aen_i(aen),
        .addr_i(addr), .rd_i(rd), .wr_i(wr), .be_i(be), .wdata_i(wdata),
        .reg_sel_o(reg_sel), .data_oe_o(data_oe), .rdata_o(rdata), .ext_cs_n_o(ext_cs_n)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic f_valid(input logic a, input logic [ADDR_W-1:2] ad);
        return !a && (ad[ADDR_W-1:4] == io_base);
    endfunction
    function automatic logic f_bsel(input logic a, input logic [ADDR_W-1:2] ad);
        return f_valid(a, ad) && (ad[3:2] == 2'b11);
    endfunction
    function automatic logic [3:0] f_sel(input logic a, input logic [ADDR_W-1:2] ad);
        if (f_valid(a, ad) && !f_bsel(a, ad) && bank_m < 4) return 4'b1 << bank_m;
        return 4'b0;
    endfunction
    function automatic logic f_cs_n(input logic a, input logic [ADDR_W-1:2] ad);
        return !(f_valid(a, ad) && bank_m == 3'd7 && !ad[3]);
    endfunction
    function automatic logic f_oe(input logic a, input logic [ADDR_W-1:2] ad, input logic r);
        return r && (f_bsel(a, ad) || (f_valid(a, ad) && bank_m < 4));
    endfunction

    // checks every combinational output against the model for inputs a/ad/r
    task automatic check_all(input string req, input logic a, input logic [ADDR_W-1:2] ad, input logic r);
        chk(reg_sel == f_sel(a, ad), {req, " sel"}, 32'(reg_sel), 32'(f_sel(a, ad)));
        chk(ext_cs_n == f_cs_n(a, ad), {req, " cs"}, 32'(ext_cs_n), 32'(f_cs_n(a, ad)));
        chk(data_oe == f_oe(a, ad, r), {req, " oe"}, 32'(data_oe), 32'(f_oe(a, ad, r)));
        if (f_bsel(a, ad))
            chk(rdata == {8'h33, 5'b0, bank_m, 16'h0}, {req, " rdata"}, rdata, {8'h33, 5'b0, bank_m, 16'h0});
    endtask

    task automatic access(input logic a, input logic [ADDR_W-1:2] ad, input logic r, input logic w,
                          input logic [3:0] b, input logic [31:0] d, input string req);
        @(negedge clk);
        aen = a; addr = ad; rd = r; wr = w; be = b; wdata = d;
        #2;
        check_all(req, a, ad, r);
        @(posedge clk);
        if (w && f_bsel(a, ad) && b[2]) bank_m = d[18:16];
        #1;
        rd = 1'b0; wr = 1'b0;
    endtask

    task automatic set_bank(input logic [2:0] bk);
        access(1'b0, {io_base, 2'b11}, 1'b0, 1'b1, 4'b1100, {13'h0, bk, 16'h0}, "R3");
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        io_base = 12'h30A; as_s = 0; aen = 1; addr = '0; rd = 0; wr = 0; be = 0; wdata = 0;
        bank_m = 3'd0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset bank reads as 0, signature present
        access(1'b0, {io_base, 2'b11}, 1'b1, 1'b0, 4'b1111, 0, "R1");
        chk(rdata[23:16] == 8'h00, "R1 bank", rdata[23:16], 0);

        // R2 aen high and base mismatch
        access(1'b1, {io_base, 2'b00}, 1'b1, 1'b0, 4'b1111, 0, "R2");
        access(1'b0, {io_base ^ 12'h001, 2'b01}, 1'b1, 1'b0, 4'b1111, 0, "R2");
        chk(data_oe == 1'b0 && reg_sel == 0, "R2 mismatch", {data_oe, reg_sel}, 0);

        // R3 lane-3 only write ignored
        access(1'b0, {io_base, 2'b11}, 1'b0, 1'b1, 4'b1000, 32'hFFFF_FFFF, "R3");
        access(1'b0, {io_base, 2'b11}, 1'b1, 1'b0, 4'b0100, 0, "R3");
        chk(rdata[18:16] == 3'd0, "R3 lane3 ignored", rdata[18:16], 0);

        // R5 each internal bank
        for (int k = 0; k < 4; k++) begin
            set_bank(3'(k));
            access(1'b0, {io_base, 2'(k % 3)}, 1'b1, 1'b0, 4'b0011, 0, "R5");
            chk(reg_sel == (4'b1 << k), "R5 onehot", reg_sel, 4'b1 << k);
        end

        // R7 empty banks 4..6; R3 bank select still writable there
        for (int k = 4; k < 7; k++) begin
            set_bank(3'(k));
            access(1'b0, {io_base, 2'b01}, 1'b1, 1'b0, 4'b1111, 0, "R7");
            chk(data_oe == 1'b0 && reg_sel == 0, "R7 empty", {data_oe, reg_sel}, 0);
            access(1'b0, {io_base, 2'b11}, 1'b1, 1'b0, 4'b1000, 0, "R4");
            chk(data_oe && rdata[31:24] == 8'h33, "R4 sig", rdata[31:24], 8'h33);
        end

        // R6 bank 7 lower half vs upper half
        set_bank(3'd7);
        access(1'b0, {io_base, 2'b00}, 1'b1, 1'b0, 4'b0001, 0, "R6");
        chk(ext_cs_n == 1'b0, "R6 low half", ext_cs_n, 0);
        access(1'b0, {io_base, 2'b10}, 1'b1, 1'b0, 4'b0001, 0, "R6");
        chk(ext_cs_n == 1'b1, "R6 high half", ext_cs_n, 1);

        // R8 strobe freezes address and aen
        @(negedge clk); aen = 0; addr = {io_base, 2'b01}; rd = 1;
        @(negedge clk); as_s = 1;
        @(negedge clk); aen = 1; addr = {io_base ^ 12'h0F0, 2'b10};
        #2;
        chk(ext_cs_n == 1'b0, "R8 frozen cs", ext_cs_n, 0);
        @(negedge clk); #2;
        chk(ext_cs_n == 1'b0, "R8 still frozen", ext_cs_n, 0);
        @(negedge clk); as_s = 0;
        @(negedge clk); #2;
        chk(ext_cs_n == 1'b1 && data_oe == 1'b0, "R8 transparent", {ext_cs_n, data_oe}, 2'b10);
        rd = 0;

        // random mix: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            logic [ADDR_W-1:2] ad;
            logic a, r, w;
            rv = $urandom();
            ad = {(rv[0] ? io_base : 12'($urandom())), rv[2:1]};
            a  = (rv[5:3] == 3'd0);
            r  = rv[6];
            w  = !rv[6] && rv[7];
            access(a, ad, r, w, rv[11:8], {13'h0, rv[14:12], 16'h0}, "R2-mix R3 R4 R5 R6 R7");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule